// File: doc/BRIEF.md
# Four-Bank Address Generator

This block turns one pointer register into four 16-bit memory addresses in the same cycle, one per bank of a four-way data memory. It holds eight 16-bit pointers. An operation picks one pointer, adds a column term and a row term to it, and then adds a per-bank stride to the result. Bank k gets k times that stride. The pointer is then post-modified by one of five arithmetic rules and written back at the clock edge.

An extended mode shapes the address in three further ways. Modulo mode reloads the pointer with a top address when the post-modified value lands on a bottom address. Bit-reversed mode reverses the address bits but keeps a configurable number of high bits in place. Table mode takes the column and row terms from four table registers chosen by a 4-bit selector. The addresses are combinational, computed from the stored pointer. A separate load port initialises the pointers.

Top module: `quad_bank_agu`

## Requirements
- R1: After a synchronous active-low reset all eight pointers read zero. With zero offsets, every bank address is 0x0000.
- R2: Bank address k (k = 0..3, bank k in bits [16k+15:16k] of `bank_addr`) equals base + column + row + k×`ind_ofs`, wrapped modulo 2^16. It is combinational in the current pointer and the inputs.
- R3: When `op_valid` is high, `post_mode` selects the write-back value as follows. 001 gives pointer+1, 010 gives pointer−1, 011 gives pointer+`idx_val`, 100 gives pointer+`imm_ofs` (11-bit, zero-extended) and 101 gives pointer−`imm_ofs`. All of these wrap modulo 2^16 and raise `ptr_wb_en`.
- R4: `post_mode` 000 (plain indirect) and the reserved codes 110 and 111 keep `ptr_wb_en` low. The selected pointer is then unchanged in the next cycle. With `op_valid` low, nothing is written back either.
- R5: With `ext_mode` 01 (modulo), a post-modified value equal to `bot_addr` is replaced by `top_addr` before it is written back.
- R6: With `ext_mode` 10 (bit-reversed), the base is the 16-bit reversal of the pointer, except that the top `keep_cnt` bits keep the pointer's own values. For example, 0x0F0F with a count of 2 gives 0x30F0, and a count of 16 or more gives the pointer unchanged. Write-back arithmetic uses the unreversed pointer.
- R7: With `ext_mode` 11 (table), the column term is table register `tab_sel[3:2]` and the row term is table register `tab_sel[1:0]`. Table register n sits in `tab_regs[16n+15:16n]`, and `col_ofs` has no effect.
- R8: In `ext_mode` 00, 01 and 10 the column term is `col_ofs` and the row term is zero.
- R9: `ld_en` writes `ld_val` into pointer `ld_idx` at the clock edge. When it targets the same pointer as a write-back in that cycle, the load wins.
- R10: A write-back becomes visible at the clock edge. The next cycle's addresses use the updated pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Pointer load strobe |
| ld_idx | input | 3 | Pointer to load |
| ld_val | input | 16 | Value to load |
| op_valid | input | 1 | An address operation is issued this cycle |
| ptr_sel | input | 3 | Pointer used by the operation |
| post_mode | input | 3 | Post-modify rule |
| ext_mode | input | 2 | 00 none, 01 modulo, 10 bit-reversed, 11 table |
| idx_val | input | 16 | Value of the selected index register |
| imm_ofs | input | 11 | Instruction offset |
| top_addr | input | 16 | Modulo reload value |
| bot_addr | input | 16 | Modulo trigger value |
| keep_cnt | input | 5 | High bits left unreversed |
| col_ofs | input | 16 | Column offset register |
| ind_ofs | input | 16 | Per-bank stride |
| tab_sel | input | 4 | Table selector: column in [3:2], row in [1:0] |
| tab_regs | input | 64 | Four table registers |
| bank_addr | output | 64 | Four bank addresses |
| ptr_wb_en | output | 1 | Write-back taking place |
| ptr_wb_val | output | 16 | Write-back value |

## Verification
The bank addresses and the write-back strobe and value are combinational, so they are due in the same cycle as the stimulus that produces them. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A write-back or load only shows up one rising edge later, through the addresses of the following operation on that pointer. The bench therefore updates its own pointer model at the rising edge and compares the next cycle's addresses against it. Random operations run over every mode, with the bottom address often set one step ahead so that modulo reloads occur. Directed cases cover the reversal examples, the table selection, the reserved codes and a load colliding with a write-back.

// File: rtl/agu_pkg.sv
// agu_pkg: shared widths, extended-mode encoding and the partial bit reversal.
// Assumes a 16-bit address space; the keep count is wide enough to hold AW.
package agu_pkg;
    localparam int AW = 16;
    localparam int KW = $clog2(AW + 1);

    typedef enum logic [1:0] {
        EXT_NONE = 2'b00,
        EXT_MOD  = 2'b01,
        EXT_REV  = 2'b10,
        EXT_TAB  = 2'b11
    } ext_mode_t;

    // Reverse the address bits, leaving the top 'keep' bits where they are.
    function automatic logic [AW-1:0] rev_keep(input logic [AW-1:0] p,
                                               input logic [KW-1:0] keep);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++)
            r[i] = (i >= AW - int'(keep)) ? p[i] : p[AW-1-i];
        return r;
    endfunction
endpackage

// File: rtl/agu_ptr_file.sv
// agu_ptr_file: the pointer registers, with one read port, one write-back
// port and one load port. The load has priority on a same-index collision.
module agu_ptr_file #(
    parameter int NPTR = 8,
    parameter int AW   = 16,
    localparam int PW  = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_val,
    input  logic          wb_en,
    input  logic [PW-1:0] wb_idx,
    input  logic [AW-1:0] wb_val,
    input  logic          ld_en,
    input  logic [PW-1:0] ld_idx,
    input  logic [AW-1:0] ld_val
);
    logic [AW-1:0] regs [NPTR];

    // Read the selected pointer combinationally.
    assign rd_val = regs[rd_idx];

    // Reset, load or write back each pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) regs[i] <= '0;
        end else begin
            if (wb_en && !(ld_en && ld_idx == wb_idx)) regs[wb_idx] <= wb_val;
            if (ld_en) regs[ld_idx] <= ld_val;
        end
    end

    // R9
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> regs[$past(ld_idx)] == $past(ld_val));

    // R10
    writeback_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(ld_en && ld_idx == wb_idx)) |=> regs[$past(wb_idx)] == $past(wb_val));

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (regs[rd_idx] == '0));
endmodule

// File: rtl/agu_ptr_update.sv
// agu_ptr_update: works out the post-modified pointer and whether it is
// written back, including the modulo reload. Purely combinational.
module agu_ptr_update
    import agu_pkg::*;
#(
    parameter int OW = 11
) (
    input  logic          valid,
    input  logic [2:0]    mode,
    input  logic [1:0]    ext,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] idx_val,
    input  logic [OW-1:0] imm,
    input  logic [AW-1:0] top_addr,
    input  logic [AW-1:0] bot_addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    logic [AW-1:0] imm_x;
    logic [AW-1:0] stepped;

    assign imm_x = AW'(imm);

    // Apply the post-modify arithmetic selected by the mode code.
    always_comb begin
        unique case (mode)
            3'b001:  stepped = ptr + AW'(1);
            3'b010:  stepped = ptr - AW'(1);
            3'b011:  stepped = ptr + idx_val;
            3'b100:  stepped = ptr + imm_x;
            3'b101:  stepped = ptr - imm_x;
            default: stepped = ptr;
        endcase
    end

    // Enable write-back for the five modifying codes; reload on a modulo hit.
    always_comb begin
        wb_en  = valid && (mode inside {3'b001, 3'b010, 3'b011, 3'b100, 3'b101});
        wb_val = (ext == EXT_MOD && stepped == bot_addr) ? top_addr : stepped;
    end
endmodule

// File: rtl/agu_bank_gen.sv
// agu_bank_gen: adds the column and row terms to the base, then fans the sum
// out to the banks with a per-bank stride multiple. All sums wrap.
module agu_bank_gen #(
    parameter int NBANK = 4,
    parameter int AW    = 16
) (
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       col,
    input  logic [AW-1:0]       row,
    input  logic [AW-1:0]       stride,
    output logic [NBANK*AW-1:0] addr
);
    logic [AW-1:0] origin;

    // Common part shared by every bank.
    assign origin = base + col + row;

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        // Bank k sits k strides away from the origin.
        assign addr[k*AW +: AW] = origin + AW'(k) * stride;
    end
endmodule

// File: rtl/quad_bank_agu.sv
// quad_bank_agu: top level. Selects a pointer, forms the base (plain or
// partially reversed), picks the column and row terms (registers or table)
// and issues four bank addresses. The pointer write-back happens at the edge.
module quad_bank_agu
    import agu_pkg::*;
#(
    parameter int NPTR  = 8,
    parameter int NBANK = 4,
    parameter int NTAB  = 4,
    parameter int OW    = 11,
    localparam int PW   = $clog2(NPTR),
    localparam int TW   = $clog2(NTAB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [PW-1:0]      ld_idx,
    input  logic [AW-1:0]      ld_val,
    input  logic               op_valid,
    input  logic [PW-1:0]      ptr_sel,
    input  logic [2:0]         post_mode,
    input  logic [1:0]         ext_mode,
    input  logic [AW-1:0]      idx_val,
    input  logic [OW-1:0]      imm_ofs,
    input  logic [AW-1:0]      top_addr,
    input  logic [AW-1:0]      bot_addr,
    input  logic [KW-1:0]      keep_cnt,
    input  logic [AW-1:0]      col_ofs,
    input  logic [AW-1:0]      ind_ofs,
    input  logic [2*TW-1:0]    tab_sel,
    input  logic [NTAB*AW-1:0] tab_regs,
    output logic [NBANK*AW-1:0] bank_addr,
    output logic               ptr_wb_en,
    output logic [AW-1:0]      ptr_wb_val
);
    logic [AW-1:0] ptr_cur;
    logic [AW-1:0] base;
    logic [AW-1:0] col_term;
    logic [AW-1:0] row_term;

    agu_ptr_file #(.NPTR(NPTR), .AW(AW)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ptr_sel), .rd_val(ptr_cur),
        .wb_en(ptr_wb_en), .wb_idx(ptr_sel), .wb_val(ptr_wb_val),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val)
    );

    agu_ptr_update #(.OW(OW)) u_upd (
        .valid(op_valid), .mode(post_mode), .ext(ext_mode), .ptr(ptr_cur),
        .idx_val(idx_val), .imm(imm_ofs), .top_addr(top_addr),
        .bot_addr(bot_addr), .wb_en(ptr_wb_en), .wb_val(ptr_wb_val)
    );

    // Form the base and choose column and row terms for the current mode.
    always_comb begin
        base     = (ext_mode == EXT_REV) ? rev_keep(ptr_cur, keep_cnt) : ptr_cur;
        col_term = col_ofs;
        row_term = '0;
        if (ext_mode == EXT_TAB) begin
            col_term = tab_regs[int'(tab_sel[2*TW-1:TW])*AW +: AW];
            row_term = tab_regs[int'(tab_sel[TW-1:0])*AW +: AW];
        end
    end

    agu_bank_gen #(.NBANK(NBANK), .AW(AW)) u_banks (
        .base(base), .col(col_term), .row(row_term), .stride(ind_ofs),
        .addr(bank_addr)
    );

    // R2
    bank_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_addr[2*AW-1:AW] - bank_addr[AW-1:0]) == ind_ofs);

    // R4
    hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_mode == 3'b000 || post_mode[2:1] == 2'b11 || !op_valid) |-> !ptr_wb_en);

    // R5
    modulo_never_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wb_en && ext_mode == EXT_MOD && top_addr != bot_addr) |-> ptr_wb_val != bot_addr);

    // R10
    hold_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && post_mode == 3'b000 && !ld_en) |=> $stable(ptr_cur) || ptr_sel != $past(ptr_sel));
endmodule

// File: tb/quad_bank_agu_test.sv
module quad_bank_agu_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ld_en = 0;
    logic [2:0]  ld_idx = 0;
    logic [15:0] ld_val = 0;
    logic        op_valid = 0;
    logic [2:0]  ptr_sel = 0;
    logic [2:0]  post_mode = 0;
    logic [1:0]  ext_mode = 0;
    logic [15:0] idx_val = 0;
    logic [10:0] imm_ofs = 0;
    logic [15:0] top_addr = 0;
    logic [15:0] bot_addr = 0;
    logic [4:0]  keep_cnt = 0;
    logic [15:0] col_ofs = 0;
    logic [15:0] ind_ofs = 0;
    logic [3:0]  tab_sel = 0;
    logic [63:0] tab_regs = 0;
    logic [63:0] bank_addr;
    logic        ptr_wb_en;
    logic [15:0] ptr_wb_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] mp [8];

    always #2.5 clk = ~clk;

    quad_bank_agu uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .op_valid(op_valid), .ptr_sel(ptr_sel), .post_mode(post_mode),
        .ext_mode(ext_mode), .idx_val(idx_val), .imm_ofs(imm_ofs),
        .top_addr(top_addr), .bot_addr(bot_addr), .keep_cnt(keep_cnt),
        .col_ofs(col_ofs), .ind_ofs(ind_ofs), .tab_sel(tab_sel),
        .tab_regs(tab_regs), .bank_addr(bank_addr), .ptr_wb_en(ptr_wb_en),
        .ptr_wb_val(ptr_wb_val)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rev(logic [15:0] p, logic [4:0] keep);
        logic [15:0] r, m;
        for (int i = 0; i < 16; i++) r[15-i] = p[i];
        m = (keep >= 16) ? 16'hFFFF : ~(16'hFFFF >> keep);
        return (p & m) | (r & ~m);
    endfunction

    function automatic logic [15:0] model_addr(int k);
        logic [15:0] b, c, r;
        b = (ext_mode == 2'b10) ? model_rev(mp[ptr_sel], keep_cnt) : mp[ptr_sel];
        c = (ext_mode == 2'b11) ? tab_regs[16*tab_sel[3:2] +: 16] : col_ofs;
        r = (ext_mode == 2'b11) ? tab_regs[16*tab_sel[1:0] +: 16] : 16'h0;
        return 16'(b + c + r + 16'(k) * ind_ofs);
    endfunction

    function automatic bit model_wb_en();
        return op_valid && post_mode >= 3'd1 && post_mode <= 3'd5;
    endfunction

    function automatic logic [15:0] model_wb_val();
        logic [15:0] p, n;
        p = mp[ptr_sel];
        case (post_mode)
            3'd1: n = p + 16'd1;
            3'd2: n = p - 16'd1;
            3'd3: n = p + idx_val;
            3'd4: n = p + {5'd0, imm_ofs};
            3'd5: n = p - {5'd0, imm_ofs};
            default: n = p;
        endcase
        if (ext_mode == 2'b01 && n == bot_addr) n = top_addr;
        return n;
    endfunction

    // Check the current outputs, then let one edge pass and update the model.
    task automatic step();
        string tag;
        bit we;
        logic [15:0] wv;
        #1;
        case (ext_mode)
            2'b10: tag = "R6";
            2'b11: tag = "R7";
            default: tag = "R2";
        endcase
        for (int k = 0; k < 4; k++) chk(tag, bank_addr[16*k +: 16], model_addr(k));
        we = model_wb_en();
        wv = model_wb_val();
        chk(we ? "R3" : "R4", {15'd0, ptr_wb_en}, {15'd0, we});
        if (we) chk((ext_mode == 2'b01) ? "R5" : "R3", ptr_wb_val, wv);
        @(posedge clk);
        if (we && !(ld_en && ld_idx == ptr_sel)) mp[ptr_sel] = wv;
        if (ld_en) mp[ld_idx] = ld_val;
        @(negedge clk);
    endtask

    task automatic load(logic [2:0] i, logic [15:0] v);
        ld_en = 1; ld_idx = i; ld_val = v; op_valid = 0;
        step();
        ld_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        for (int i = 0; i < 8; i++) mp[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: after reset every pointer reads zero, so all addresses are zero
        for (int i = 0; i < 8; i++) begin
            ptr_sel = 3'(i);
            #1;
            chk("R1", bank_addr[15:0], 16'h0);
            chk("R1", bank_addr[63:48], 16'h0);
            @(negedge clk);
        end
        // R6: directed reversal examples
        load(3'd2, 16'h0F0F);
        ptr_sel = 2; ext_mode = 2'b10; keep_cnt = 2; step();
        #1 chk("R6", bank_addr[15:0], 16'h30F0);
        keep_cnt = 16; #1 chk("R6", bank_addr[15:0], 16'h0F0F);
        keep_cnt = 0; #1 chk("R6", bank_addr[15:0], 16'hF0F0);
        @(negedge clk);
        // R7: table mode ignores col_ofs, picks TR2 as column and TR1 as row
        ext_mode = 2'b11; tab_regs = {16'h4000, 16'h0300, 16'h0020, 16'h0001};
        tab_sel = 4'b1001; col_ofs = 16'h7777; ind_ofs = 16'h0010;
        #1 chk("R7", bank_addr[15:0], 16'h0F0F + 16'h0300 + 16'h0020);
        chk("R7", bank_addr[63:48], 16'h0F0F + 16'h0320 + 16'h0030);
        @(negedge clk);
        // R8: plain mode uses col_ofs and no row term
        ext_mode = 2'b00;
        #1 chk("R8", bank_addr[15:0], 16'h0F0F + 16'h7777);
        @(negedge clk);
        // R5: modulo reload when the step hits the bottom address
        ext_mode = 2'b01; op_valid = 1; post_mode = 3'b001;
        bot_addr = 16'h0F10; top_addr = 16'h0100; step();
        op_valid = 0; ext_mode = 2'b00; col_ofs = 0; ind_ofs = 0;
        #1 chk("R5", bank_addr[15:0], 16'h0100);
        @(negedge clk);
        // R4: reserved code leaves the pointer in place
        op_valid = 1; post_mode = 3'b111; step();
        op_valid = 0;
        #1 chk("R4", bank_addr[15:0], 16'h0100);
        @(negedge clk);
        // R9: load wins over a same-index write-back
        op_valid = 1; post_mode = 3'b001; ld_en = 1; ld_idx = 2; ld_val = 16'hABCD;
        step();
        ld_en = 0; op_valid = 0;
        #1 chk("R9", bank_addr[15:0], 16'hABCD);
        @(negedge clk);
        // R10: random operations, the model tracks write-backs edge by edge
        for (int n = 0; n < 3000; n++) begin
            op_valid  = ($urandom % 8) != 0;
            ptr_sel   = 3'($urandom);
            post_mode = 3'($urandom);
            ext_mode  = 2'($urandom);
            idx_val   = 16'($urandom);
            imm_ofs   = 11'($urandom);
            keep_cnt  = 5'($urandom % 18);
            col_ofs   = 16'($urandom);
            ind_ofs   = 16'($urandom);
            tab_sel   = 4'($urandom);
            tab_regs  = {32'($urandom), 32'($urandom)};
            top_addr  = 16'($urandom);
            bot_addr  = ($urandom % 2) ? mp[ptr_sel] + 16'd1 : 16'($urandom);
            ld_en     = ($urandom % 10) == 0;
            ld_idx    = ($urandom % 2) ? ptr_sel : 3'($urandom);
            ld_val    = 16'($urandom);
            step();
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule